// File: doc/BRIEF.md
# UART Modem Status Tracker

This block keeps the modem status byte of a 16550-style UART. Four active-low modem input pins (clear-to-send, data-set-ready, ring indicator, carrier detect) are synchronized to the core clock. The block reports their complemented levels and records sticky change flags until the CPU reads the register. A modem-status interrupt request is raised while an enabled change flag is pending.

In loopback mode the four status levels come from the modem control outputs instead of the pins. Change detection runs on the looped-back values, so software and benches can produce every change flag without driving the pins. Reads use a single-cycle strobe with a 32-bit data word. The register has no write path.

Top module: `uart_modem_status`

## Requirements
- R1: After reset, `rd_data` is zero and `irq` is low. Bits 31:8 of `rd_data` always read as zero.
- R2: With `mcr_bits[4]` low, bit 7 shows the complement of `dcd_n`, bit 6 of `ri_n`, bit 5 of `dsr_n` and bit 4 of `cts_n`. A pin change shows up after the third rising clock edge, and not after the second.
- R3: With `mcr_bits[4]` high, one clock after the control bits change, bit 7 = `mcr_bits[3]`, bit 6 = `mcr_bits[2]`, bit 5 = `mcr_bits[0]` and bit 4 = `mcr_bits[1]`. The pins have no effect in this mode.
- R4: Bit 0 is set when bit 4 changes in either direction. Bit 1 is set when bit 5 changes, and bit 3 when bit 7 changes. These flags are set on the same edge as the level change and stay set until a read.
- R5: Bit 2 is set only when bit 6 goes from 1 to 0, which is the ring pin going from low to high. A 0-to-1 change of bit 6 leaves bit 2 unchanged.
- R6: While `rd_stb` is high, `rd_data` shows the current value. Bits 3:0 are cleared on the rising edge that ends the read cycle. Bits 7:4 are not affected by a read.
- R7: If a change is detected on the same edge that ends a read, the new flag is set and the older flags are cleared.
- R8: `irq` is high whenever `ms_irq_en` is high and bit 3, bit 2 or bit 1 is set.
- R9: A set bit 0 drives `irq` high only while `autoflow_en` is low.
- R10: `irq` is a level. It falls as soon as `ms_irq_en` goes low, or once a read has cleared the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_data | output | 32 | Status word |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| mcr_bits | input | 5 | Modem control: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| autoflow_en | input | 1 | Automatic flow control on; masks the CTS-change interrupt |
| irq | output | 1 | Modem-status interrupt request, level |

## Verification
The assertions assume that `mcr_bits`, `rd_stb` and the two enables are synchronous to `clk`. They also assume that a read that leaves the status levels unchanged sees no new change flag. Only the looped-back control bits are related to the output one cycle later. The asynchronous pins are not tied to any cycle, because their latency depends on the synchronizer. The bench changes all inputs on falling clock edges and holds each read strobe for exactly one cycle. It exercises the pin path only while loopback is off. It samples outputs on falling edges, where the synchronizer latency gives an exact cycle count.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_CD  = 3;

  typedef logic [LINES-1:0] line_vec_t;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcr_t;

  // Loopback cross-map into status order {CD, RI, DSR, CTS}
  function automatic line_vec_t loop_map(mcr_t m);
    return {m.out2, m.out1, m.dtr, m.rts};
  endfunction
endpackage

// File: rtl/msr_pin_sync.sv
module msr_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] sync_n
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pin_n[b]};
    end
    assign sync_n[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/msr_change_track.sv
module msr_change_track
  import msr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lvl_in,
  input  logic      clr,
  output line_vec_t lvl_q,
  output line_vec_t delta_q
);
  line_vec_t hit;

  for (genvar i = 0; i < LINES; i++) begin : g_det
    if (i == IDX_RI) begin : g_trail
      assign hit[i] = lvl_q[i] & ~lvl_in[i];
    end else begin : g_any
      assign hit[i] = lvl_q[i] ^ lvl_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_in;
      delta_q <= (delta_q & ~{LINES{clr}}) | hit;
    end
  end
endmodule

// File: rtl/msr_irq_gen.sv
module msr_irq_gen
  import msr_pkg::*;
(
  input  line_vec_t delta,
  input  logic      ien,
  input  logic      afe,
  output logic      irq
);
  logic cts_req;
  logic other_req;

  always_comb begin
    cts_req   = delta[IDX_CTS] & ~afe;
    other_req = delta[IDX_DSR] | delta[IDX_RI] | delta[IDX_CD];
    irq       = ien & (cts_req | other_req);
  end
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import msr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  input  logic [4:0]        mcr_bits,
  input  logic              ms_irq_en,
  input  logic              autoflow_en,
  output logic              irq
);
  localparam int PAD_W = DATA_W - 2 * LINES;

  mcr_t      mcr;
  line_vec_t pins_n;
  line_vec_t pins_sync_n;
  line_vec_t live_lvl;
  line_vec_t lvl_q;
  line_vec_t delta_q;

  assign mcr    = mcr_t'(mcr_bits);
  assign pins_n = {dcd_n, ri_n, dsr_n, cts_n};

  msr_pin_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (pins_n),
    .sync_n (pins_sync_n)
  );

  assign live_lvl = mcr.loop ? loop_map(mcr) : ~pins_sync_n;

  msr_change_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_in  (live_lvl),
    .clr     (rd_stb),
    .lvl_q   (lvl_q),
    .delta_q (delta_q)
  );

  msr_irq_gen u_irq (
    .delta (delta_q),
    .ien   (ms_irq_en),
    .afe   (autoflow_en),
    .irq   (irq)
  );

  assign rd_data = {{PAD_W{1'b0}}, lvl_q, delta_q};
endmodule

// File: rtl/msr_chk.sv
module msr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic [31:0] rd_data,
  input logic [4:0]  mcr_bits,
  input logic        ms_irq_en,
  input logic        autoflow_en,
  input logic        irq
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mcr_bits[4])) |->
      rd_data[7:4] == {$past(mcr_bits[3]), $past(mcr_bits[2]),
                       $past(mcr_bits[0]), $past(mcr_bits[1])});

  // R4
  cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_data[4] != $past(rd_data[4])) |-> rd_data[0]);

  // R4
  dsr_cd_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (rd_data[5] != $past(rd_data[5]) || rd_data[7] != $past(rd_data[7])))
      |-> (rd_data[1] || rd_data[5] == $past(rd_data[5])) &&
          (rd_data[3] || rd_data[7] == $past(rd_data[7])));

  // R4
  sticky_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(rd_stb)) |->
      (rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]));

  // R5
  teri_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(rd_data[2])) |-> ($past(rd_data[6]) && !rd_data[6]));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rd_stb) && rd_data[7:4] == $past(rd_data[7:4]))
      |-> rd_data[3:0] == 4'h0);

  // R9
  autoflow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autoflow_en && rd_data[3:1] == 3'b000) |-> !irq);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_irq_en |-> !irq);
endmodule

bind uart_modem_status msr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_stb      (rd_stb),
  .rd_data     (rd_data),
  .mcr_bits    (mcr_bits),
  .ms_irq_en   (ms_irq_en),
  .autoflow_en (autoflow_en),
  .irq         (irq)
);

// File: tb/uart_modem_status_test.sv
module uart_modem_status_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [31:0] rd_data;
  logic        cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic [4:0]  mcr_bits = 5'b0;
  logic        ms_irq_en = 1'b0, autoflow_en = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_modem_status uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .mcr_bits(mcr_bits), .ms_irq_en(ms_irq_en), .autoflow_en(autoflow_en),
    .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [31:0] exp_val);
    rd_stb = 1'b1;
    chk32(req, rd_data, exp_val);
    tick(1);
    rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    chk32("R1 reset value", rd_data, 32'h0);
    chk1("R1 reset irq", irq, 1'b0);
  endtask

  task automatic t_pins();
    cts_n = 1'b0;
    tick(2);
    chk32("R2 not before third edge", rd_data, 32'h0);
    tick(1);
    chk32("R2 R4 cts level and DCTS", rd_data, 32'h11);
    tick(5);
    chk32("R4 DCTS sticky", rd_data, 32'h11);
    do_read("R6 read returns value", 32'h11);
    chk32("R6 deltas cleared, level kept", rd_data, 32'h10);
    dsr_n = 1'b0; dcd_n = 1'b0; ri_n = 1'b0;
    tick(3);
    chk32("R2 R4 R5 dsr cd set, no TERI on ring rise", rd_data, 32'hFA);
    do_read("R6 read", 32'hFA);
    ri_n = 1'b1;
    tick(3);
    chk32("R5 TERI on ring trailing edge", rd_data, 32'hB4);
    chk1("R10 irq off while disabled", irq, 1'b0);
    do_read("R6 read", 32'hB4);
    cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1;
    tick(3);
    chk32("R4 changes back to inactive", rd_data, 32'h0B);
    do_read("R6 read", 32'h0B);
    chk32("R1 R6 all clear", rd_data, 32'h0);
  endtask

  task automatic t_loop();
    mcr_bits = 5'b1_0010;
    tick(1);
    chk32("R3 RTS to CTS", rd_data, 32'h11);
    mcr_bits = 5'b1_1101;
    tick(1);
    chk32("R3 R4 R5 OUT2 OUT1 DTR map", rd_data, 32'hEB);
    do_read("R6 read", 32'hEB);
    cts_n = 1'b0; dcd_n = 1'b0;
    tick(4);
    chk32("R3 pins ignored in loopback", rd_data, 32'hE0);
    cts_n = 1'b1; dcd_n = 1'b1;
    tick(3);
    chk32("R3 pins ignored in loopback", rd_data, 32'hE0);
  endtask

  task automatic t_irq();
    ms_irq_en = 1'b1; autoflow_en = 1'b1;
    mcr_bits = 5'b1_1111;
    tick(1);
    chk32("R4 DCTS pending", rd_data, 32'hF1);
    chk1("R9 DCTS masked by autoflow", irq, 1'b0);
    autoflow_en = 1'b0;
    tick(1);
    chk1("R9 DCTS raises irq without autoflow", irq, 1'b1);
    autoflow_en = 1'b1;
    do_read("R6 read", 32'hF1);
    chk1("R10 irq cleared by read", irq, 1'b0);
    mcr_bits = 5'b1_1011;
    tick(1);
    chk32("R5 TERI in loopback", rd_data, 32'hB4);
    chk1("R8 TERI raises irq", irq, 1'b1);
    ms_irq_en = 1'b0;
    tick(1);
    chk1("R10 irq falls with enable", irq, 1'b0);
    ms_irq_en = 1'b1;
    tick(1);
    chk1("R8 irq back with enable", irq, 1'b1);
    do_read("R6 read", 32'hB4);
    chk1("R10 irq cleared by read", irq, 1'b0);
    ms_irq_en = 1'b0;
  endtask

  task automatic t_collide();
    mcr_bits = 5'b1_0011;
    tick(1);
    chk32("R4 DCD pending", rd_data, 32'h38);
    rd_stb = 1'b1;
    mcr_bits = 5'b1_0010;
    chk32("R6 read shows pre-change value", rd_data, 32'h38);
    tick(1);
    rd_stb = 1'b0;
    chk32("R7 new DDSR kept, DCD cleared", rd_data, 32'h12);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pins();
    t_loop();
    t_irq();
    t_collide();
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end
endmodule